// File: doc/BRIEF.md
# Lifting-Based Angle Rotation Unit

This unit turns a pair of signed transform coefficients through one of eight fixed angles. The pair is usually two coefficients that sit in mirrored positions about the diagonal of a transform block. Each clock it accepts a new pair, a 3-bit angle index and a valid strobe. Four cycles later it presents the rotated pair with a matching valid.

The rotation uses three lifting steps, so it needs three constant products per pair where a plain matrix would need four. Each product is formed by a fixed shift-and-add network, and there is one network for each angle at each step. The angle index picks among them. Index zero means no rotation: the unrotated pair is selected through a multiplexer. Its delay is exactly the same as for every other angle, so the consumer never sees the latency change.

Top module: `lift_rotator`

## Requirements
- R1: While `rst` is high at a rising edge, the next output has `out_valid`=0, `out_x`=0 and `out_y`=0.
- R2: `out_valid` equals the `in_valid` that was presented 4 clock cycles earlier. The input is sampled at rising edge n and the result is visible after edge n+3.
- R3: An angle index k in 0..7 selects θ = k·π/8. The lifting constants are P = −p/1024 and U = u/1024. For k=1..7 the values of p are 204, 424, 684, 1024, 1533, 2472, 5148. For k=1..7 the values of u are 392, 724, 946, 1024, 946, 724, 392. For k=0, p and u are both 0.
- R4: The data path computes three steps in order. First x1 = S(x + R(−p·y)). Then y1 = S(y + R(u·x1)). Then x2 = S(x1 + R(−p·y1)). Here R(v) = floor((v + 512) / 1024). The result is `out_x`=x2 and `out_y`=y1.
- R5: S clamps each step's sum to the signed 16-bit range [−32768, 32767], so results saturate instead of wrapping.
- R6: For angle index 0, `out_x` and `out_y` equal the input pair exactly, with the same 4-cycle latency.
- R7: An input pair of (0, 0) gives (0, 0) at every angle.
- R8: A new pair may be presented on every cycle. Each result depends only on its own input pair and angle, even when consecutive pairs use different angles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair valid |
| in_angle | input | 3 | Angle index k, θ = k·π/8 |
| in_x | input | 16 | First coefficient, signed |
| in_y | input | 16 | Second coefficient, signed |
| out_valid | output | 1 | Output pair valid |
| out_x | output | 16 | Rotated first coefficient, signed |
| out_y | output | 16 | Rotated second coefficient, signed |

## Verification
Every result is due exactly four rising edges after its inputs are sampled, and this holds for all angles including the bypass index. The bench drives a new pair on each falling edge and pushes its own expected value into a four-deep delay line. On each later falling edge it compares the outputs with the entry that has just left that line, so each comparison lines up with the fourth edge after the drive. The same four-cycle distance is used in the checker, which compares the valid flag, bypassed pairs and zero pairs against the inputs sampled four edges earlier.

// File: rtl/lift_rotator.sv
module lift_rotator #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2:0]          in_angle,
  input  logic signed [W-1:0] in_x,
  input  logic signed [W-1:0] in_y,
  output logic                out_valid,
  output logic signed [W-1:0] out_x,
  output logic signed [W-1:0] out_y
);
  localparam int FB = 10;
  localparam int CB = 14;
  localparam int PW = W + CB + 2;
  localparam int NANG = 8;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FB - 1);
  localparam logic signed [PW-1:0] SMAX = (PW'(1) <<< (W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] SMIN = -(PW'(1) <<< (W - 1));

  function automatic int pmag(input int k);
    case (k)
      1: return 204;
      2: return 424;
      3: return 684;
      4: return 1024;
      5: return 1533;
      6: return 2472;
      7: return 5148;
      default: return 0;
    endcase
  endfunction

  function automatic int umag(input int k);
    case (k)
      1, 7: return 392;
      2, 6: return 724;
      3, 5: return 946;
      4: return 1024;
      default: return 0;
    endcase
  endfunction

  function automatic logic signed [PW-1:0] shadd(input logic signed [W-1:0] v, input int mag);
    logic signed [PW-1:0] acc;
    logic signed [PW-1:0] ext;
    acc = '0;
    ext = PW'(v);
    for (int i = 0; i < CB; i++)
      if (mag[i]) acc = acc + (ext <<< i);
    return acc;
  endfunction

  function automatic logic signed [W-1:0] lift(input logic signed [W-1:0] base,
                                               input logic signed [PW-1:0] prod);
    logic signed [PW-1:0] s;
    s = PW'(base) + ((prod + HALF) >>> FB);
    if (s > SMAX) s = SMAX;
    else if (s < SMIN) s = SMIN;
    return s[W-1:0];
  endfunction

  logic                v0, v1, v2, v3;
  logic [2:0]          a0, a1, a2;
  logic signed [W-1:0] x0, y0, x1, y1, x2, y2, x3, y3;

  logic signed [PW-1:0] pa [NANG];
  logic signed [PW-1:0] ub [NANG];
  logic signed [PW-1:0] pc [NANG];

  assign pa[0] = '0;
  assign ub[0] = '0;
  assign pc[0] = '0;

  for (genvar g = 1; g < NANG; g++) begin : g_ang
    assign pa[g] = -shadd(y0, pmag(g));
    assign ub[g] =  shadd(x1, umag(g));
    assign pc[g] = -shadd(y2, pmag(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v0 <= 1'b0; v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      a0 <= '0; a1 <= '0; a2 <= '0;
      x0 <= '0; y0 <= '0; x1 <= '0; y1 <= '0;
      x2 <= '0; y2 <= '0; x3 <= '0; y3 <= '0;
    end else begin
      v0 <= in_valid;
      a0 <= in_angle;
      x0 <= in_x;
      y0 <= in_y;

      v1 <= v0;
      a1 <= a0;
      x1 <= (a0 == 3'd0) ? x0 : lift(x0, pa[a0]);
      y1 <= y0;

      v2 <= v1;
      a2 <= a1;
      x2 <= x1;
      y2 <= (a1 == 3'd0) ? y1 : lift(y1, ub[a1]);

      v3 <= v2;
      x3 <= (a2 == 3'd0) ? x2 : lift(x2, pc[a2]);
      y3 <= y2;
    end
  end

  assign out_valid = v3;
  assign out_x     = x3;
  assign out_y     = y3;
endmodule

// File: rtl/lift_rotator_chk.sv
module lift_rotator_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [2:0]          in_angle,
  input logic signed [W-1:0] in_x,
  input logic signed [W-1:0] in_y,
  input logic                out_valid,
  input logic signed [W-1:0] out_x,
  input logic signed [W-1:0] out_y
);
  logic [2:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else if (run_cnt != 3'd4) run_cnt <= run_cnt + 3'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_x == '0 && out_y == '0));

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  assert_bypass_pair_R6: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 3'd4 && $past(in_valid, 4) && $past(in_angle, 4) == 3'd0)
      |-> (out_x == $past(in_x, 4) && out_y == $past(in_y, 4)));

  assert_zero_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (run_cnt == 3'd4 && $past(in_valid, 4) && $past(in_x, 4) == '0 && $past(in_y, 4) == '0)
      |-> (out_x == '0 && out_y == '0));
endmodule

bind lift_rotator lift_rotator_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_angle(in_angle),
  .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
);

// File: tb/lift_rotator_tb.sv
module lift_rotator_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] in_angle = '0;
  logic signed [15:0] in_x = '0;
  logic signed [15:0] in_y = '0;
  logic out_valid;
  logic signed [15:0] out_x, out_y;

  int n_tests = 0;
  int n_fail = 0;

  logic        e_v [4];
  logic [15:0] e_x [4];
  logic [15:0] e_y [4];
  string       e_t [4];

  always #2 clk = ~clk;

  lift_rotator dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_angle(in_angle),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
  );

  function automatic longint pk(input int k);
    case (k)
      1: return 204; 2: return 424; 3: return 684; 4: return 1024;
      5: return 1533; 6: return 2472; 7: return 5148;
      default: return 0;
    endcase
  endfunction

  function automatic longint uk(input int k);
    case (k)
      1: return 392; 2: return 724; 3: return 946; 4: return 1024;
      5: return 946; 6: return 724; 7: return 392;
      default: return 0;
    endcase
  endfunction

  function automatic longint rnd(input longint v);
    return (v + 512) >>> 10;
  endfunction

  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int a, input int x, input int y, input string tag);
    longint x1, y1, x2;
    @(negedge clk);
    check("R2", longint'(out_valid), longint'(e_v[3]), "out_valid");
    if (e_v[3]) begin
      check(e_t[3], longint'(out_x), longint'($signed(e_x[3])), "out_x");
      check(e_t[3], longint'(out_y), longint'($signed(e_y[3])), "out_y");
    end
    for (int i = 3; i > 0; i--) begin
      e_v[i] = e_v[i-1]; e_x[i] = e_x[i-1]; e_y[i] = e_y[i-1]; e_t[i] = e_t[i-1];
    end
    x1 = sat(longint'(x) + rnd(-pk(a) * longint'(y)));
    y1 = sat(longint'(y) + rnd(uk(a) * x1));
    x2 = sat(x1 + rnd(-pk(a) * y1));
    e_v[0] = v;
    e_x[0] = 16'(x2);
    e_y[0] = 16'(y1);
    e_t[0] = tag;
    in_valid = v;
    in_angle = 3'(a);
    in_x = 16'(x);
    in_y = 16'(y);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      e_v[i] = 1'b0; e_x[i] = '0; e_y[i] = '0; e_t[i] = "R2";
    end
    in_valid = 1'b1; in_x = 16'sd1234; in_y = -16'sd77; in_angle = 3'd3;
    repeat (6) @(negedge clk);
    check("R1", longint'(out_valid), 0, "out_valid in reset");
    check("R1", longint'(out_x), 0, "out_x in reset");
    check("R1", longint'(out_y), 0, "out_y in reset");
    in_valid = 1'b0; in_x = '0; in_y = '0; in_angle = '0;
    rst = 1'b0;

    // R3: each angle on a known pair
    for (int a = 0; a < 8; a++) drive(1'b1, a, 1000, 0, "R3");
    for (int a = 0; a < 8; a++) drive(1'b1, a, 0, 1000, "R3");
    // R6: bypass with extreme values
    drive(1'b1, 0, 32767, -32768, "R6");
    drive(1'b1, 0, -5, 12345, "R6");
    // R7: zero pair
    for (int a = 0; a < 8; a++) drive(1'b1, a, 0, 0, "R7");
    // R5: saturation corners
    drive(1'b1, 7, 32767, -32768, "R5");
    drive(1'b1, 7, -32768, 32767, "R5");
    drive(1'b1, 6, 32767, 32767, "R5");
    drive(1'b1, 4, -32768, -32768, "R5");
    // R2: gaps in valid
    drive(1'b0, 2, 500, 500, "R2");
    drive(1'b1, 2, 500, 500, "R2");
    drive(1'b0, 5, -300, 40, "R2");
    // R8: back-to-back with changing angles
    for (int i = 0; i < 16; i++) drive(1'b1, i % 8, 3000 - i * 400, i * 250 - 2000, "R8");
    // R4: constrained random stream
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2000; i++) begin
      int a, x, y;
      logic v;
      a = int'($urandom_range(7, 0));
      v = ($urandom_range(9, 0) != 0);
      if ($urandom_range(3, 0) == 0) begin
        x = int'($urandom_range(65535, 0)) - 32768;
        y = int'($urandom_range(65535, 0)) - 32768;
      end else begin
        x = int'($urandom_range(8191, 0)) - 4096;
        y = int'($urandom_range(8191, 0)) - 4096;
      end
      drive(v, a, x, y, "R4");
    end
    for (int i = 0; i < 5; i++) drive(1'b0, 0, 0, 0, "R2");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule